// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the clocked, half-duplex mode of a serial port. The block drives a shift clock on one pin and moves data over a single bidirectional data pin. A host write to the transmit buffer sends its eight bits out, least significant first. When receive is enabled, a host clear of the receive flag clocks eight bits in from the data pin. One bit takes one machine cycle of `CYC_PER_BIT` core clocks. The shift clock is low for the first half of each bit and high for the second half.

Transmit data changes at the start of each bit and stays put across the rising shift-clock edge and for the rest of the bit. Receive data is captured on the rising edge. When a transfer finishes, it raises a transmit-done or receive-done flag, and that flag stays set until the host clears it. While the port is idle, the clock and data pins rest high. While the port is receiving, the data driver is released.

Top module: `shift_mode_serial`

## Requirements
- R1: After reset ti_o=0, ri_o=0, rx_data_o=0, sclk_o=1, sdata_o=1 and sdata_oe_o=1. While idle, sclk_o, sdata_o and sdata_oe_o stay 1.
- R2: A buf_wr_i pulse while idle starts a transmit. The eight bits of buf_wdata_i appear on sdata_o in the order bit 0 to bit 7. Each bit lasts CYC_PER_BIT clocks: sclk_o is low for the first CYC_PER_BIT/2 clocks and high for the rest.
- R3: During a transmit, sdata_o changes only while sclk_o is low. It is stable at each rising sclk_o edge and until sclk_o falls again.
- R4: At the end of the eighth transmit bit, ti_o sets, sclk_o stays high and sdata_o returns to 1.
- R5: A ri_clr_i pulse with rx_en_i=1 while idle starts a receive. During the receive, sdata_oe_o=0 and sclk_o follows the same bit timing as R2.
- R6: During a receive, sdata_i is sampled at each rising sclk_o edge, and the first sample is bit 0. At the end of the eighth bit, ri_o sets and rx_data_o shows the assembled byte.
- R7: A ri_clr_i pulse with rx_en_i=0 starts no transfer: sclk_o stays high.
- R8: A buf_wr_i pulse during an active transfer is ignored. The byte in flight is unchanged and no further transfer follows.
- R9: ti_o and ri_o stay set until ti_clr_i or ri_clr_i is pulsed. The clear takes effect at the next clock.
- R10: If buf_wr_i and ri_clr_i arrive in the same idle cycle with rx_en_i=1, the transmit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock (oscillator rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| buf_wr_i | input | 1 | Write strobe for the transmit buffer |
| buf_wdata_i | input | DATA_W | Byte to transmit |
| rx_en_i | input | 1 | Receive enable |
| ti_clr_i | input | 1 | Clear transmit-done flag |
| ri_clr_i | input | 1 | Clear receive-done flag; with rx_en_i it starts a receive |
| ti_o | output | 1 | Transmit-done flag |
| ri_o | output | 1 | Receive-done flag |
| rx_data_o | output | DATA_W | Last received byte |
| sclk_o | output | 1 | Shift clock, idles high |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe_o | output | 1 | Data pin output enable |
| sdata_i | input | 1 | Data pin input value |

## Verification
The bench builds the block with CYC_PER_BIT=12 and DATA_W=8, which are the machine-cycle length and byte width the port is defined around. With these values the clock edge that samples the data falls on clock 6 of each bit. The 12-clock spacing between rising edges can be measured directly. A mid-transfer write lands well inside one byte, so R8 can be seen at the pins. The all-zero, all-one and single-high-bit patterns expose bit ordering and fill errors.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_TX   = 2'd1,
    XF_RX   = 2'd2
  } xfer_e;
endpackage

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int CYC_PER_BIT = 12,
  parameter int DATA_W      = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_tx_i,
  input  logic  start_rx_i,
  output xfer_e mode_o,
  output logic  sclk_o,
  output logic  sample_o,
  output logic  shift_o,
  output logic  done_o
);
  localparam int PH_W = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_PER_BIT - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(CYC_PER_BIT / 2);
  localparam logic [PH_W-1:0] PH_PRE  = PH_W'(CYC_PER_BIT / 2 - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

  xfer_e           mode_q;
  logic [PH_W-1:0] ph_q;
  logic [BC_W-1:0] bc_q;
  logic            active;
  logic            bit_end;

  assign active  = (mode_q != XF_IDLE);
  assign bit_end = active && (ph_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= XF_IDLE;
      ph_q   <= '0;
      bc_q   <= '0;
    end else if (!active) begin
      ph_q <= '0;
      bc_q <= '0;
      if (start_tx_i)      mode_q <= XF_TX;
      else if (start_rx_i) mode_q <= XF_RX;
    end else if (bit_end) begin
      ph_q <= '0;
      if (bc_q == BC_LAST) mode_q <= XF_IDLE;
      else                 bc_q   <= bc_q + 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign mode_o   = mode_q;
  // low half then high half of every bit
  assign sclk_o   = !(active && (ph_q < PH_HALF));
  assign sample_o = active && (ph_q == PH_PRE);
  assign shift_o  = bit_end && (bc_q != BC_LAST);
  assign done_o   = bit_end && (bc_q == BC_LAST);
endmodule

// File: rtl/ssp_shreg.sv
module ssp_shreg
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  xfer_e             mode_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              sdata_i,
  output logic              tx_bit_o,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '1;
    end else if (load_i) begin
      sh_q <= load_data_i;
    end else if (mode_i == XF_TX && shift_i) begin
      sh_q <= {1'b1, sh_q[DATA_W-1:1]};
    end else if (mode_i == XF_RX && sample_i) begin
      sh_q <= {sdata_i, sh_q[DATA_W-1:1]};
    end
  end

  assign tx_bit_o = sh_q[0];
  assign q_o      = sh_q;
endmodule

// File: rtl/ssp_flags.sv
module ssp_flags
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  xfer_e             mode_i,
  input  logic [DATA_W-1:0] shreg_i,
  input  logic              ti_clr_i,
  input  logic              ri_clr_i,
  output logic              ti_o,
  output logic              ri_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic              ti_q, ri_q;
  logic [DATA_W-1:0] rxd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ti_q  <= 1'b0;
      ri_q  <= 1'b0;
      rxd_q <= '0;
    end else begin
      if (done_i && mode_i == XF_TX) ti_q <= 1'b1;
      else if (ti_clr_i)             ti_q <= 1'b0;
      if (done_i && mode_i == XF_RX) begin
        ri_q  <= 1'b1;
        rxd_q <= shreg_i;
      end else if (ri_clr_i) begin
        ri_q <= 1'b0;
      end
    end
  end

  assign ti_o      = ti_q;
  assign ri_o      = ri_q;
  assign rx_data_o = rxd_q;
endmodule

// File: rtl/shift_mode_serial.sv
module shift_mode_serial
  import ssp_pkg::*;
#(
  parameter int CYC_PER_BIT = 12,
  parameter int DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              rx_en_i,
  input  logic              ti_clr_i,
  input  logic              ri_clr_i,
  output logic              ti_o,
  output logic              ri_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  input  logic              sdata_i
);
  xfer_e             mode;
  logic              sample, shift, done;
  logic              start_tx, start_rx;
  logic              tx_bit;
  logic [DATA_W-1:0] sh_q;
  logic              busy;
  logic              rx_mode;

  assign busy     = (mode != XF_IDLE);
  assign rx_mode  = (mode == XF_RX);
  // transmit has priority over a same-cycle receive start
  assign start_tx = buf_wr_i && !busy;
  assign start_rx = ri_clr_i && rx_en_i && !busy && !buf_wr_i;

  ssp_seq #(
    .CYC_PER_BIT(CYC_PER_BIT),
    .DATA_W     (DATA_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_tx_i(start_tx),
    .start_rx_i(start_rx),
    .mode_o    (mode),
    .sclk_o    (sclk_o),
    .sample_o  (sample),
    .shift_o   (shift),
    .done_o    (done)
  );

  ssp_shreg #(
    .DATA_W(DATA_W)
  ) u_shreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_tx),
    .load_data_i(buf_wdata_i),
    .mode_i     (mode),
    .sample_i   (sample),
    .shift_i    (shift),
    .sdata_i    (sdata_i),
    .tx_bit_o   (tx_bit),
    .q_o        (sh_q)
  );

  ssp_flags #(
    .DATA_W(DATA_W)
  ) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .mode_i   (mode),
    .shreg_i  (sh_q),
    .ti_clr_i (ti_clr_i),
    .ri_clr_i (ri_clr_i),
    .ti_o     (ti_o),
    .ri_o     (ri_o),
    .rx_data_o(rx_data_o)
  );

  assign sdata_o    = (mode == XF_TX) ? tx_bit : 1'b1;
  assign sdata_oe_o = !rx_mode;
endmodule

// File: rtl/shift_mode_serial_chk.sv
module shift_mode_serial_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic ti_o,
  input logic ri_o,
  input logic ti_clr_i,
  input logic ri_clr_i,
  input logic busy,
  input logic rx_mode
);
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sclk_o && sdata_o && sdata_oe_o));

  p_tx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !rx_mode && sclk_o) |-> $stable(sdata_o));

  p_ti_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ti_o) |-> (!busy && $past(busy) && !$past(rx_mode)));

  p_rx_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_mode |-> !sdata_oe_o);

  p_ri_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ri_o) |-> (!busy && $past(busy) && $past(rx_mode)));

  p_ti_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ti_o && !ti_clr_i) |=> ti_o);

  p_ri_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_o && !ri_clr_i) |=> ri_o);
endmodule

bind shift_mode_serial shift_mode_serial_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sclk_o    (sclk_o),
  .sdata_o   (sdata_o),
  .sdata_oe_o(sdata_oe_o),
  .ti_o      (ti_o),
  .ri_o      (ri_o),
  .ti_clr_i  (ti_clr_i),
  .ri_clr_i  (ri_clr_i),
  .busy      (busy),
  .rx_mode   (rx_mode)
);

// File: tb/shift_mode_serial_tb.sv
module shift_mode_serial_tb;
  localparam int CPB = 12;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          buf_wr_i = 1'b0;
  logic [DW-1:0] buf_wdata_i = '0;
  logic          rx_en_i = 1'b0;
  logic          ti_clr_i = 1'b0;
  logic          ri_clr_i = 1'b0;
  logic          ti_o, ri_o, sclk_o, sdata_o, sdata_oe_o;
  logic [DW-1:0] rx_data_o;
  logic          sdata_i = 1'b1;

  always #4 clk = ~clk;

  shift_mode_serial #(.CYC_PER_BIT(CPB), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .buf_wr_i(buf_wr_i), .buf_wdata_i(buf_wdata_i),
    .rx_en_i(rx_en_i), .ti_clr_i(ti_clr_i), .ri_clr_i(ri_clr_i), .ti_o(ti_o),
    .ri_o(ri_o), .rx_data_o(rx_data_o), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .sdata_oe_o(sdata_oe_o), .sdata_i(sdata_i)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 0;

  logic [DW-1:0] tx_q[$];
  logic [DW-1:0] rx_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  int            cyc = 0;
  int            rise_cnt = 0;
  int            tx_bits = 0;
  int            last_rise = 0;
  int            period_bad = 0;
  int            hold_bad = 0;
  logic          held = 1'b1;
  logic [DW-1:0] tx_acc = '0;
  logic          sclk_prev = 1'b1;
  logic          ri_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (sclk_o && !sclk_prev) begin
        rise_cnt++;
        if (sdata_oe_o) begin
          if (tx_bits != 0 && (cyc - last_rise) != CPB) period_bad++;
          last_rise = cyc;
          held = sdata_o;
          tx_acc[tx_bits[2:0]] = sdata_o;
          tx_bits++;
          if (tx_bits == DW) begin
            if (tx_q.size() == 0) begin
              check(1'b0, "R2 unexpected tx byte", int'(tx_acc), 0);
            end else begin
              logic [DW-1:0] e;
              e = tx_q.pop_front();
              check(tx_acc == e, "R2 tx byte", int'(tx_acc), int'(e));
            end
            check(period_bad == 0, "R2 bit period", period_bad, 0);
            check(hold_bad == 0, "R3 data hold", hold_bad, 0);
            tx_bits = 0; period_bad = 0; hold_bad = 0;
          end
        end
      end else if (sclk_o && sdata_oe_o && tx_bits != 0 && sdata_o != held) begin
        hold_bad++;
      end
      if (ri_o && !ri_prev) begin
        if (rx_q.size() == 0) begin
          check(1'b0, "R6 unexpected rx byte", int'(rx_data_o), 0);
        end else begin
          logic [DW-1:0] e;
          e = rx_q.pop_front();
          check(rx_data_o == e, "R6 rx byte", int'(rx_data_o), int'(e));
        end
      end
    end
    sclk_prev = sclk_o;
    ri_prev   = ri_o;
  end

  task automatic send(input logic [DW-1:0] b, input bit expect_it);
    if (expect_it) tx_q.push_back(b);
    @(negedge clk); buf_wr_i = 1'b1; buf_wdata_i = b;
    @(negedge clk); buf_wr_i = 1'b0;
  endtask

  task automatic wait_ti();
    while (!ti_o) @(negedge clk);
  endtask

  task automatic clear_ti();
    @(negedge clk); ti_clr_i = 1'b1;
    @(negedge clk); ti_clr_i = 1'b0;
  endtask

  task automatic receive(input logic [DW-1:0] b);
    rx_q.push_back(b);
    @(negedge clk); ri_clr_i = 1'b1;
    @(negedge clk); ri_clr_i = 1'b0;
    for (int k = 0; k < DW; k++) begin
      while (sclk_o) @(negedge clk);
      sdata_i = b[k];
      if (k == 3) check(sdata_oe_o == 1'b0, "R5 data pin released", sdata_oe_o, 0);
      while (!sclk_o) @(negedge clk);
    end
    while (!ri_o) @(negedge clk);
    sdata_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int rc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ti_o == 0, "R1 ti reset", ti_o, 0);
    check(ri_o == 0, "R1 ri reset", ri_o, 0);
    check(rx_data_o == 0, "R1 rx_data reset", rx_data_o, 0);
    check(sclk_o && sdata_o && sdata_oe_o, "R1 idle lines", {sclk_o, sdata_o, sdata_oe_o}, 7);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check(sclk_o && sdata_o && sdata_oe_o, "R1 idle after reset", {sclk_o, sdata_o, sdata_oe_o}, 7);

    // R2/R3/R4 basic transmit
    send(8'hA5, 1);
    wait_ti();
    check(sclk_o == 1, "R4 sclk high at end", sclk_o, 1);
    check(sdata_o == 1, "R4 data idle high", sdata_o, 1);
    repeat (40) @(negedge clk);
    check(ti_o == 1, "R9 ti sticky", ti_o, 1);
    clear_ti();
    check(ti_o == 0, "R9 ti cleared", ti_o, 0);

    // R2 further patterns
    send(8'h00, 1); wait_ti(); clear_ti();
    send(8'hFF, 1); wait_ti(); clear_ti();
    send(8'h80, 1); wait_ti(); clear_ti();
    send(8'h3C, 1); wait_ti(); clear_ti();

    // R8 write during transfer ignored
    send(8'h11, 1);
    repeat (30) @(negedge clk);
    send(8'h77, 0);
    wait_ti();
    rc = rise_cnt;
    repeat (4 * CPB) @(negedge clk);
    check(rise_cnt == rc, "R8 no follow-on transfer", rise_cnt, rc);
    check(tx_q.size() == 0, "R8 in-flight byte kept", tx_q.size(), 0);
    clear_ti();

    // R7 ri clear with receive disabled
    rc = rise_cnt;
    @(negedge clk); ri_clr_i = 1'b1;
    @(negedge clk); ri_clr_i = 1'b0;
    repeat (3 * CPB) @(negedge clk);
    check(rise_cnt == rc && sclk_o == 1, "R7 no receive when disabled", rise_cnt, rc);
    check(ri_o == 0, "R7 ri stays clear", ri_o, 0);

    // R5/R6 receive
    rx_en_i = 1'b1;
    receive(8'h5A);
    repeat (30) @(negedge clk);
    check(ri_o == 1, "R9 ri sticky", ri_o, 1);
    receive(8'hC3);
    receive(8'h01);
    @(negedge clk); ri_clr_i = 1'b1; rx_en_i = 1'b0;
    @(negedge clk); ri_clr_i = 1'b0;
    check(ri_o == 0, "R9 ri cleared", ri_o, 0);

    // R10 simultaneous write and ri clear
    rx_en_i = 1'b1;
    tx_q.push_back(8'h96);
    @(negedge clk); buf_wr_i = 1'b1; buf_wdata_i = 8'h96; ri_clr_i = 1'b1;
    @(negedge clk); buf_wr_i = 1'b0; ri_clr_i = 1'b0;
    repeat (20) @(negedge clk);
    check(sdata_oe_o == 1, "R10 transmit wins", sdata_oe_o, 1);
    wait_ti();
    check(ri_o == 0, "R10 no receive flag", ri_o, 0);
    rx_en_i = 1'b0;
    clear_ti();
    repeat (5) @(negedge clk);
    check(tx_q.size() == 0 && rx_q.size() == 0, "R2 scoreboard drained",
          tx_q.size() + rx_q.size(), 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule